// File: doc/BRIEF.md
# Lock-Bit Protection Controller

The block holds the three non-volatile lock bits of an embedded code memory. From them it builds a cumulative protection level, and it grants or denies four kinds of access according to that level:
- table reads of internal code bytes issued by code running from external program space;
- byte programming through the programming port;
- readback verify through the programming port;
- external code execution.

Each access request enters on its own input. The matching grant output is the request ANDed with the permission that the current level gives.

The lock bits behave as a four-state machine, one state per level:
- `LVL_OPEN`: no bit programmed, the erased state the cells hold from the start.
- `LVL_L1`: bit 1 programmed.
- `LVL_L2`: bits 1 and 2 programmed.
- `LVL_L3`: all three bits programmed.

The transitions are:
- `advance`: a program request that names the next unprogrammed bit moves the level one step up.
- `erase`: a chip-erase request returns the machine to `LVL_OPEN` from any state.
- `hold`: any other cycle leaves the state unchanged.

The cells ignore reset. Nothing outputs the level directly.

While reset is low, the block samples the external-access pin on every clock edge. Once reset is released, it keeps the last sampled value. While at least lock bit 1 is programmed, a mismatch flag reports any difference between that latched value and the live pin.

Top module: `lock_guard`

## Requirements
- R1: In `LVL_OPEN` (the state the cells hold before any program request), every grant output equals its request input, in the same cycle and whether or not reset is low.
- R2: A program request with `lock_prog_sel` equal to the current level moves the level one step up at that clock edge. The level codes are 0 for `LVL_OPEN`, 1 for `LVL_L1`, 2 for `LVL_L2` and 3 for `LVL_L3`. Select code 0 names bit 1, code 1 names bit 2 and code 2 names bit 3. The new level governs the grants from that edge onward.
- R3: A program request whose select is not equal to the current level has no effect on the grants. This covers a bit already programmed, a bit out of order and select code 3.
- R4: A chip-erase request returns the level to `LVL_OPEN` at that clock edge. It takes priority over a program request in the same cycle.
- R5: From `LVL_L1` up, `code_rd_ext_ok` and `port_prog_ok` stay 0.
- R6: From `LVL_L2` up, `port_verify_ok` also stays 0.
- R7: In `LVL_L3`, `ext_exec_ok` also stays 0. Below `LVL_L3`, it equals `ext_exec_req`.
- R8: The pin latch loads `ext_access_pin` at every clock edge while `rst_n` is 0, and holds that value while `rst_n` is 1. `ext_pin_mismatch` is 1 exactly when `rst_n` is 1, the level is at least `LVL_L1`, and the latched value differs from the live pin.
- R9: Asserting reset leaves the lock level unchanged.
- R10: In `LVL_OPEN`, `ext_pin_mismatch` stays 0 whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the pin is sampled while it is low |
| lock_prog_req | input | 1 | Request to program one lock bit |
| lock_prog_sel | input | 2 | Bit to program: 0, 1 or 2 for bits 1, 2 or 3 |
| chip_erase | input | 1 | Clears all lock bits |
| ext_access_pin | input | 1 | Live level of the external-access pin |
| code_rd_ext_req | input | 1 | Table read of internal code from external program space |
| port_prog_req | input | 1 | Byte program through the programming port |
| port_verify_req | input | 1 | Readback verify through the programming port |
| ext_exec_req | input | 1 | External code execution |
| code_rd_ext_ok | output | 1 | Grant for the table read |
| port_prog_ok | output | 1 | Grant for byte programming |
| port_verify_ok | output | 1 | Grant for verify |
| ext_exec_ok | output | 1 | Grant for external execution |
| ext_pin_mismatch | output | 1 | Latched and live pin levels differ while locked |

## Verification
The grants and the mismatch flag are combinational from the inputs and the stored state, so they are due in the same cycle as the request or pin change that drives them. A program or erase request changes the stored level at the next clock edge, so its effect is due one cycle after the stimulus. A pin value is captured by the last edge before reset is released. The driver changes inputs 1 ns after a rising edge and queues one expected item per cycle. The monitor compares that item at the following falling edge, after the edge that applies the previous cycle's program, erase or sample request.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;
    localparam int NLOCK = 3;
    localparam int LVLW  = $clog2(NLOCK + 1);
    localparam int NACC  = 4;

    localparam int ACC_TBL    = 0;
    localparam int ACC_PROG   = 1;
    localparam int ACC_VERIFY = 2;
    localparam int ACC_EXEC   = 3;

    typedef enum logic [LVLW-1:0] {
        LVL_OPEN = 2'd0,
        LVL_L1   = 2'd1,
        LVL_L2   = 2'd2,
        LVL_L3   = 2'd3
    } lvl_e;

    // Level from which an access kind is denied.
    function automatic lvl_e acc_limit(input int kind);
        lvl_e r;
        unique case (kind)
            ACC_TBL:    r = LVL_L1;
            ACC_PROG:   r = LVL_L1;
            ACC_VERIFY: r = LVL_L2;
            default:    r = LVL_L3;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/lock_cells.sv
module lock_cells
    import lock_guard_pkg::*;
(
    input  logic            clk,
    input  logic            prog_req,
    input  logic [LVLW-1:0] prog_sel,
    input  logic            erase_req,
    output lvl_e            lvl_q
);
    // Non-volatile cells: erased from the start, untouched by reset.
    lvl_e state_q = LVL_OPEN;
    lvl_e state_d;

    always_comb begin
        state_d = state_q;
        if (erase_req) begin
            state_d = LVL_OPEN;
        end else if (prog_req && (prog_sel == state_q)) begin
            unique case (state_q)
                LVL_OPEN: state_d = LVL_L1;
                LVL_L1:   state_d = LVL_L2;
                LVL_L2:   state_d = LVL_L3;
                LVL_L3:   state_d = LVL_L3;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign lvl_q = state_q;
endmodule

// File: rtl/pin_latch.sv
module pin_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic armed,
    output logic latched,
    output logic mismatch
);
    // Samples while reset is low; holds otherwise. No defined value before a reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched <= pin;
        end
    end

    always_comb begin
        mismatch = rst_n && armed && (latched != pin);
    end
endmodule

// File: rtl/perm_decode.sv
module perm_decode
    import lock_guard_pkg::*;
(
    input  lvl_e            lvl,
    input  logic [NACC-1:0] req,
    output logic [NACC-1:0] gnt
);
    logic [NACC-1:0] allow;

    for (genvar g = 0; g < NACC; g++) begin : g_acc
        localparam lvl_e LIMIT = acc_limit(g);
        assign allow[g] = (lvl < LIMIT);
    end

    always_comb begin
        gnt = req & allow;
    end
endmodule

// File: rtl/lock_guard.sv
module lock_guard
    import lock_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock_prog_req,
    input  logic [LVLW-1:0] lock_prog_sel,
    input  logic            chip_erase,
    input  logic            ext_access_pin,
    input  logic            code_rd_ext_req,
    input  logic            port_prog_req,
    input  logic            port_verify_req,
    input  logic            ext_exec_req,
    output logic            code_rd_ext_ok,
    output logic            port_prog_ok,
    output logic            port_verify_ok,
    output logic            ext_exec_ok,
    output logic            ext_pin_mismatch
);
    lvl_e            lvl_q;
    logic            ext_latched;
    logic [NACC-1:0] req_v;
    logic [NACC-1:0] gnt_v;

    lock_cells u_cells (
        .clk       (clk),
        .prog_req  (lock_prog_req),
        .prog_sel  (lock_prog_sel),
        .erase_req (chip_erase),
        .lvl_q     (lvl_q)
    );

    pin_latch u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_access_pin),
        .armed    (lvl_q != LVL_OPEN),
        .latched  (ext_latched),
        .mismatch (ext_pin_mismatch)
    );

    always_comb begin
        req_v             = '0;
        req_v[ACC_TBL]    = code_rd_ext_req;
        req_v[ACC_PROG]   = port_prog_req;
        req_v[ACC_VERIFY] = port_verify_req;
        req_v[ACC_EXEC]   = ext_exec_req;
    end

    perm_decode u_dec (
        .lvl (lvl_q),
        .req (req_v),
        .gnt (gnt_v)
    );

    assign code_rd_ext_ok = gnt_v[ACC_TBL];
    assign port_prog_ok   = gnt_v[ACC_PROG];
    assign port_verify_ok = gnt_v[ACC_VERIFY];
    assign ext_exec_ok    = gnt_v[ACC_EXEC];
endmodule

// File: rtl/lock_guard_chk.sv
module lock_guard_chk
    import lock_guard_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic chip_erase,
    input lvl_e lvl_q,
    input logic ext_latched,
    input logic code_rd_ext_ok,
    input logic port_prog_ok,
    input logic port_verify_ok,
    input logic ext_exec_ok,
    input logic ext_pin_mismatch
);
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_erase |=> ((lvl_q == $past(lvl_q)) || (int'(lvl_q) == int'($past(lvl_q)) + 1)));

    a_r4_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase |=> (lvl_q == LVL_OPEN));

    a_r5_locked_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != LVL_OPEN) |-> (!code_rd_ext_ok && !port_prog_ok));

    a_r6_no_verify: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == LVL_L2 || lvl_q == LVL_L3) |-> !port_verify_ok);

    a_r7_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == LVL_L3) |-> !ext_exec_ok);

    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ext_latched));

    a_r10_open_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == LVL_OPEN) |-> !ext_pin_mismatch);
endmodule

bind lock_guard lock_guard_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .chip_erase       (chip_erase),
    .lvl_q            (lvl_q),
    .ext_latched      (ext_latched),
    .code_rd_ext_ok   (code_rd_ext_ok),
    .port_prog_ok     (port_prog_ok),
    .port_verify_ok   (port_verify_ok),
    .ext_exec_ok      (ext_exec_ok),
    .ext_pin_mismatch (ext_pin_mismatch)
);

// File: tb/lock_guard_bench.sv
`timescale 1ns/1ps
module lock_guard_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prg = 1'b0;
    logic [1:0] sel = 2'd0;
    logic ers = 1'b0;
    logic pin = 1'b1;
    logic [3:0] req = 4'b0;
    logic [3:0] gnt;
    logic mm;

    always #2.5 clk = ~clk;

    lock_guard u_lock_guard (
        .clk              (clk),
        .rst_n            (rst_n),
        .lock_prog_req    (prg),
        .lock_prog_sel    (sel),
        .chip_erase       (ers),
        .ext_access_pin   (pin),
        .code_rd_ext_req  (req[0]),
        .port_prog_req    (req[1]),
        .port_verify_req  (req[2]),
        .ext_exec_req     (req[3]),
        .code_rd_ext_ok   (gnt[0]),
        .port_prog_ok     (gnt[1]),
        .port_verify_ok   (gnt[2]),
        .ext_exec_ok      (gnt[3]),
        .ext_pin_mismatch (mm)
    );

    typedef struct {
        string      tag;
        logic [3:0] gnt;
        logic       mm;
    } item_t;

    item_t q[$];
    int checks = 0;
    int failures = 0;
    int lvl_m = 0;
    logic latch_m = 1'b0;
    bit done = 1'b0;

    // Driver: apply one cycle of stimulus, queue the expected result, update the model.
    task automatic step(input string tag, input logic r, input logic [3:0] rq,
                        input logic p, input logic [1:0] s, input logic e, input logic pn);
        item_t it;
        logic [3:0] allow;
        @(posedge clk);
        #1;
        rst_n = r; req = rq; prg = p; sel = s; ers = e; pin = pn;
        allow[0] = (lvl_m < 1);
        allow[1] = (lvl_m < 1);
        allow[2] = (lvl_m < 2);
        allow[3] = (lvl_m < 3);
        it.tag = tag;
        it.gnt = rq & allow;
        it.mm  = r && (lvl_m >= 1) && (latch_m != pn);
        q.push_back(it);
        if (!r) latch_m = pn;
        if (e) lvl_m = 0;
        else if (p && (int'(s) == lvl_m) && lvl_m < 3) lvl_m = lvl_m + 1;
    endtask

    // Monitor: compare one queued item per cycle, mid-cycle.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (gnt !== it.gnt || mm !== it.mm) begin
                failures++;
                $display("FAIL %s gnt=%b exp=%b mm=%b exp=%b", it.tag, gnt, it.gnt, mm, it.mm);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state and grants in reset
        step("R1 reset idle",     0, 4'b0000, 0, 0, 0, 1);
        step("R1 reset idle",     0, 4'b0000, 0, 0, 0, 1);
        step("R1 grants in reset",0, 4'b1111, 0, 0, 0, 1);
        step("R1 open all",       1, 4'b1111, 0, 0, 0, 1);
        step("R1 open 0101",      1, 4'b0101, 0, 0, 0, 1);
        step("R1 open 1010",      1, 4'b1010, 0, 0, 0, 1);
        step("R10 open pin low",  1, 4'b0000, 0, 0, 0, 0);
        // R3 out-of-order and invalid selects ignored
        step("R3 sel1 at open",   1, 4'b0000, 1, 1, 0, 1);
        step("R3 check open",     1, 4'b1111, 1, 3, 0, 1);
        step("R3 check open",     1, 4'b1111, 0, 0, 0, 1);
        // R2 advance to L1, R5 blocking, R8 mismatch
        step("R2 prog bit1",      1, 4'b0000, 1, 0, 0, 1);
        step("R5 L1 grants",      1, 4'b1111, 0, 0, 0, 1);
        step("R8 pin match",      1, 4'b0100, 0, 0, 0, 1);
        step("R8 pin differs",    1, 4'b1000, 0, 0, 0, 0);
        step("R3 reprog bit1",    1, 4'b0000, 1, 0, 0, 1);
        step("R3 skip to bit3",   1, 4'b1111, 1, 2, 0, 1);
        step("R3 still L1",       1, 4'b1111, 0, 0, 0, 1);
        // R9 reset keeps level, R8 relatch with pin low
        step("R9 reset at L1",    0, 4'b1111, 0, 0, 0, 0);
        step("R9 reset at L1",    0, 4'b1111, 0, 0, 0, 0);
        step("R9 level kept",     1, 4'b1111, 0, 0, 0, 0);
        step("R8 relatched differs", 1, 4'b0000, 0, 0, 0, 1);
        // R6, R7
        step("R2 prog bit2",      1, 4'b0000, 1, 1, 0, 0);
        step("R6 L2 grants",      1, 4'b1111, 0, 0, 0, 0);
        step("R2 prog bit3",      1, 4'b0000, 1, 2, 0, 0);
        step("R7 L3 grants",      1, 4'b1111, 0, 0, 0, 0);
        step("R7 L3 pin differs", 1, 4'b1000, 1, 3, 0, 1);
        // R4 erase priority
        step("R4 erase+prog",     1, 4'b0000, 1, 3, 1, 0);
        step("R4 open after erase", 1, 4'b1111, 0, 0, 0, 1);
        step("R2 prog bit1 again",1, 4'b0000, 1, 0, 0, 0);
        step("R4 erase from L1",  1, 4'b1111, 0, 0, 1, 0);
        step("R4 open again",     1, 4'b1111, 0, 0, 0, 1);
        step("R10 open quiet",    1, 4'b0000, 0, 0, 0, 1);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule